// File: doc/BRIEF.md
# Interlaced Video Sync Timing Generator

This block turns a pixel clock into the timing skeleton an external NTSC/PAL encoder needs: an active-low horizontal sync, an active-low vertical sync, a data-enable strobe for the active picture, a field indicator, and the current pixel and half-line positions. Horizontal timing is counted in pixel clocks. All vertical timing is counted in half-line units, so a vertical edge can fall in the middle of a line. This is what lets the odd and even fields of an interlaced frame be offset by half a line.

The vertical settings come in two sets: one for odd fields and one for even fields. With interlace on, the fields alternate and each one runs on its own set. With interlace off, every field is an odd field and the even set is never read. Vertical settings, and the interlace choice, are sampled when a field begins. Horizontal settings are sampled at the first line start at or after a field begins. A change made in the middle of a field therefore never produces a partly altered field.

Three state machines make up the block:
- **Run control.** States `T_IDLE` and `T_RUN`. It goes from idle to run on the first clock with the enable high, and back to idle on any clock with the enable low.
- **Horizontal sequencer.** States `H_SYNC`, `H_BACK`, `H_ACT` and `H_FRONT`. Each state lasts its setting plus one pixel clocks. The sequence goes sync to back to active to front, and front returns to sync, which starts a new line.
- **Vertical sequencer.** States `V_SYNC`, `V_BACK`, `V_ACT` and `V_FRONT`. Each state lasts its setting plus one half-lines, in the same order. Front returns to sync, which starts the next field.

A half-line boundary is either a line start or the pixel position floor(line length / 2). All outputs are registered.

Top module: `ilace_sync_gen`

## Requirements
- R1: While `tv_en` is low, and during reset, on the next clock `hsync_n`=1, `vsync_n`=1, `de`=0, `field_odd`=1 and `hpos`=`vpos`=0.
- R2: Within a line, `hpos` counts from 0 to L-1, where L=(h_pw+1)+(h_bp+1)+(h_act+1)+(h_fp+1). `hsync_n` is 0 exactly for `hpos` 0..h_pw. The active span is `hpos` from h_pw+h_bp+2 to h_pw+h_bp+h_act+2 inclusive.
- R3: `vpos` counts half-lines from the field origin. It steps when `hpos` returns to 0 and when `hpos` reaches floor(L/2). `vsync_n` is 0 exactly for `vpos` 0..pw, where pw is the pulse setting of the current field.
- R4: A vertical pulse setting of 3 gives a `vsync_n` pulse of 2 lines (4·L/2 clocks). A setting of 4 gives 2.5 lines, so the pulse ends half a line away from the pixel position where it began.
- R5: A field lasts (pw+1)+(bp+1)+(act+1)+(fp+1) half-lines of the current field's set. The vertical active span covers `vpos` from pw+bp+2 to pw+bp+act+2 inclusive.
- R6: `de` is 1 only when the pixel position is inside the horizontal active span and the half-line position is inside the vertical active span.
- R7: With `ilace`=1, `field_odd` toggles at every field origin (1 is odd). Odd fields use the `vo_*` set and even fields use the `ve_*` set.
- R8: With `ilace`=0, `field_odd` stays 1, every field uses the `vo_*` set, and changes to `ve_*` have no effect on any output.
- R9: Vertical settings and `ilace` changed in mid-field take effect at the next field origin. Horizontal settings changed in mid-field take effect at the first line start at or after that origin.
- R10: On the first clock with `tv_en` high after it was low, the outputs show `hpos`=0, `vpos`=0, `hsync_n`=0, `vsync_n`=0 and `field_odd`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tv_en | input | 1 | Enables timing generation |
| ilace | input | 1 | 1 = interlaced (fields alternate), 0 = odd field repeated |
| h_pw | input | HW | Horizontal sync width minus one, in pixel clocks |
| h_bp | input | HW | Wait after sync before active, minus one |
| h_act | input | HW | Active pixels per line minus one |
| h_fp | input | HW | Wait after active before next sync, minus one |
| vo_pw | input | VW | Odd-field vertical pulse, half-lines minus one |
| vo_bp | input | VW | Odd-field wait after pulse, half-lines minus one |
| vo_act | input | VW | Odd-field active span, half-lines minus one |
| vo_fp | input | VW | Odd-field wait after active, half-lines minus one |
| ve_pw | input | VW | Even-field vertical pulse, half-lines minus one |
| ve_bp | input | VW | Even-field wait after pulse, half-lines minus one |
| ve_act | input | VW | Even-field active span, half-lines minus one |
| ve_fp | input | VW | Even-field wait after active, half-lines minus one |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Active-picture strobe |
| field_odd | output | 1 | 1 during odd fields |
| hpos | output | HW+3 | Pixel position within the line |
| vpos | output | VW+3 | Half-line position within the field |

## Verification
The key coincidence is a field ending in the same cycle as a line start, compared with a field ending at mid-line. In the first case, the vertical wrap and the horizontal settings reload land together. In the second, the horizontal reload has to wait for the following line start. Choosing an odd field of 22 half-lines and an even field of 23 half-lines makes field origins alternate between these two cases from frame to frame. Changing settings in mid-field then shows whether the reload lands in the right cycle. A behavioural reference model compares every output on every clock, and separate checks measure pulse lengths, field periods and the position of the mid-line edge.

// File: rtl/isg_pkg.sv
package isg_pkg;
    typedef enum logic [1:0] {H_SYNC, H_BACK, H_ACT, H_FRONT} hphase_e;
    typedef enum logic [1:0] {V_SYNC, V_BACK, V_ACT, V_FRONT} vphase_e;
    typedef enum logic       {T_IDLE, T_RUN} run_e;
endpackage

// File: rtl/isg_hseq.sv
module isg_hseq
    import isg_pkg::*;
#(
    parameter int HW = 8,
    localparam int PW = HW + 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          start,
    input  logic          ld_req,
    input  logic [HW-1:0] cfg_pw,
    input  logic [HW-1:0] cfg_bp,
    input  logic [HW-1:0] cfg_act,
    input  logic [HW-1:0] cfg_fp,
    output hphase_e       ph_nxt,
    output logic [PW-1:0] pos_nxt,
    output logic          tick_nxt,
    output logic          lstart_nxt
);
    hphase_e       ph;
    logic [HW-1:0] cnt, cnt_n, lim;
    logic [PW-1:0] pos, line_len, half;
    logic [HW-1:0] s_pw, s_bp, s_act, s_fp;
    logic          wrap;

    assign line_len = PW'(s_pw) + PW'(s_bp) + PW'(s_act) + PW'(s_fp) + PW'(4);
    assign half     = line_len >> 1;

    always_comb begin
        unique case (ph)
            H_SYNC:  lim = s_pw;
            H_BACK:  lim = s_bp;
            H_ACT:   lim = s_act;
            H_FRONT: lim = s_fp;
        endcase
    end

    always_comb begin
        ph_nxt  = ph;
        cnt_n   = cnt + 1'b1;
        pos_nxt = pos + 1'b1;
        wrap    = 1'b0;
        if (!en || start) begin
            ph_nxt  = H_SYNC;
            cnt_n   = '0;
            pos_nxt = '0;
        end else if (cnt == lim) begin
            cnt_n = '0;
            unique case (ph)
                H_SYNC:  ph_nxt = H_BACK;
                H_BACK:  ph_nxt = H_ACT;
                H_ACT:   ph_nxt = H_FRONT;
                H_FRONT: begin
                    ph_nxt  = H_SYNC;
                    pos_nxt = '0;
                    wrap    = 1'b1;
                end
            endcase
        end
    end

    assign lstart_nxt = wrap;
    assign tick_nxt   = wrap || (en && !start && (pos_nxt == half));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph  <= H_SYNC;
            cnt <= '0;
            pos <= '0;
        end else begin
            ph  <= ph_nxt;
            cnt <= cnt_n;
            pos <= pos_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_pw  <= '0;
            s_bp  <= '0;
            s_act <= '0;
            s_fp  <= '0;
        end else if (en && (start || (wrap && ld_req))) begin
            s_pw  <= cfg_pw;
            s_bp  <= cfg_bp;
            s_act <= cfg_act;
            s_fp  <= cfg_fp;
        end
    end

    // R2: the active phase never starts before sync and back wait are over
    p_act_after_bp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == H_ACT) |-> (pos >= PW'(s_pw) + PW'(s_bp) + PW'(2)));

    // R2: a line origin is always inside the sync phase
    p_origin_in_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pos == '0) |-> (ph == H_SYNC));
endmodule

// File: rtl/isg_vseq.sv
module isg_vseq
    import isg_pkg::*;
#(
    parameter int VW = 9,
    localparam int QW = VW + 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          start,
    input  logic          tick,
    input  logic          ilace,
    input  logic [VW-1:0] odd_pw,
    input  logic [VW-1:0] odd_bp,
    input  logic [VW-1:0] odd_act,
    input  logic [VW-1:0] odd_fp,
    input  logic [VW-1:0] evn_pw,
    input  logic [VW-1:0] evn_bp,
    input  logic [VW-1:0] evn_act,
    input  logic [VW-1:0] evn_fp,
    output vphase_e       ph_nxt,
    output logic [QW-1:0] pos_nxt,
    output logic          field_nxt,
    output logic          fstart_nxt
);
    vphase_e       ph;
    logic [VW-1:0] cnt, cnt_n, lim;
    logic [QW-1:0] pos;
    logic          field;
    logic [VW-1:0] s_pw, s_bp, s_act, s_fp;

    always_comb begin
        unique case (ph)
            V_SYNC:  lim = s_pw;
            V_BACK:  lim = s_bp;
            V_ACT:   lim = s_act;
            V_FRONT: lim = s_fp;
        endcase
    end

    always_comb begin
        ph_nxt     = ph;
        cnt_n      = cnt;
        pos_nxt    = pos;
        field_nxt  = field;
        fstart_nxt = 1'b0;
        if (!en || start) begin
            ph_nxt    = V_SYNC;
            cnt_n     = '0;
            pos_nxt   = '0;
            field_nxt = 1'b1;
        end else if (tick) begin
            cnt_n   = cnt + 1'b1;
            pos_nxt = pos + 1'b1;
            if (cnt == lim) begin
                cnt_n = '0;
                unique case (ph)
                    V_SYNC:  ph_nxt = V_BACK;
                    V_BACK:  ph_nxt = V_ACT;
                    V_ACT:   ph_nxt = V_FRONT;
                    V_FRONT: begin
                        ph_nxt     = V_SYNC;
                        pos_nxt    = '0;
                        fstart_nxt = 1'b1;
                        field_nxt  = ilace ? ~field : 1'b1;
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph    <= V_SYNC;
            cnt   <= '0;
            pos   <= '0;
            field <= 1'b1;
        end else begin
            ph    <= ph_nxt;
            cnt   <= cnt_n;
            pos   <= pos_nxt;
            field <= field_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_pw  <= '0;
            s_bp  <= '0;
            s_act <= '0;
            s_fp  <= '0;
        end else if (en && (start || fstart_nxt)) begin
            s_pw  <= field_nxt ? odd_pw  : evn_pw;
            s_bp  <= field_nxt ? odd_bp  : evn_bp;
            s_act <= field_nxt ? odd_act : evn_act;
            s_fp  <= field_nxt ? odd_fp  : evn_fp;
        end
    end

    // R3: the field origin always falls inside the vertical pulse
    p_origin_in_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pos == '0) |-> (ph == V_SYNC));

    // R7: the field indicator only moves at a field origin
    p_field_moves_at_origin_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(field) |-> (pos == '0));

    // R8: without interlace an odd field is followed by an odd field
    p_odd_repeats_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ilace && field) |=> field);
endmodule

// File: rtl/ilace_sync_gen.sv
module ilace_sync_gen
    import isg_pkg::*;
#(
    parameter int HW = 8,
    parameter int VW = 9,
    localparam int PW = HW + 3,
    localparam int QW = VW + 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tv_en,
    input  logic          ilace,
    input  logic [HW-1:0] h_pw,
    input  logic [HW-1:0] h_bp,
    input  logic [HW-1:0] h_act,
    input  logic [HW-1:0] h_fp,
    input  logic [VW-1:0] vo_pw,
    input  logic [VW-1:0] vo_bp,
    input  logic [VW-1:0] vo_act,
    input  logic [VW-1:0] vo_fp,
    input  logic [VW-1:0] ve_pw,
    input  logic [VW-1:0] ve_bp,
    input  logic [VW-1:0] ve_act,
    input  logic [VW-1:0] ve_fp,
    output logic          hsync_n,
    output logic          vsync_n,
    output logic          de,
    output logic          field_odd,
    output logic [PW-1:0] hpos,
    output logic [QW-1:0] vpos
);
    run_e          st, st_n;
    logic          start, pend;
    hphase_e       hph_n;
    vphase_e       vph_n;
    logic [PW-1:0] hpos_n;
    logic [QW-1:0] vpos_n;
    logic          tick_n, lstart_n, field_n, fstart_n;

    assign start = tv_en && (st == T_IDLE);

    always_comb begin
        unique case (st)
            T_IDLE: st_n = tv_en ? T_RUN : T_IDLE;
            T_RUN:  st_n = tv_en ? T_RUN : T_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= T_IDLE;
        else        st <= st_n;
    end

    // horizontal reload waits for a line start once a field has begun
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend <= 1'b0;
        else        pend <= tv_en && !start && (pend || fstart_n) && !lstart_n;
    end

    isg_hseq #(.HW(HW)) hseq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (tv_en),
        .start      (start),
        .ld_req     (pend || fstart_n),
        .cfg_pw     (h_pw),
        .cfg_bp     (h_bp),
        .cfg_act    (h_act),
        .cfg_fp     (h_fp),
        .ph_nxt     (hph_n),
        .pos_nxt    (hpos_n),
        .tick_nxt   (tick_n),
        .lstart_nxt (lstart_n)
    );

    isg_vseq #(.VW(VW)) vseq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (tv_en),
        .start      (start),
        .tick       (tick_n),
        .ilace      (ilace),
        .odd_pw     (vo_pw),
        .odd_bp     (vo_bp),
        .odd_act    (vo_act),
        .odd_fp     (vo_fp),
        .evn_pw     (ve_pw),
        .evn_bp     (ve_bp),
        .evn_act    (ve_act),
        .evn_fp     (ve_fp),
        .ph_nxt     (vph_n),
        .pos_nxt    (vpos_n),
        .field_nxt  (field_n),
        .fstart_nxt (fstart_n)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hsync_n   <= 1'b1;
            vsync_n   <= 1'b1;
            de        <= 1'b0;
            field_odd <= 1'b1;
            hpos      <= '0;
            vpos      <= '0;
        end else begin
            hsync_n   <= !(tv_en && (hph_n == H_SYNC));
            vsync_n   <= !(tv_en && (vph_n == V_SYNC));
            de        <= tv_en && (hph_n == H_ACT) && (vph_n == V_ACT);
            field_odd <= field_n;
            hpos      <= hpos_n;
            vpos      <= vpos_n;
        end
    end

    // R1: a low enable parks every output on the next clock
    p_idle_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !tv_en |=> (hsync_n && vsync_n && !de && field_odd && hpos == '0 && vpos == '0));

    // R6: the picture strobe never overlaps either sync pulse
    p_de_clear_of_sync_r6: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (hsync_n && vsync_n));
endmodule

// File: tb/ilace_sync_gen_tb_top.sv
`timescale 1ns/1ps
module ilace_sync_gen_tb_top;
    localparam int HW = 8;
    localparam int VW = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tv_en = 1'b0, ilace = 1'b0;
    logic [HW-1:0] h_pw, h_bp, h_act, h_fp;
    logic [VW-1:0] vo_pw, vo_bp, vo_act, vo_fp, ve_pw, ve_bp, ve_act, ve_fp;
    logic hsync_n, vsync_n, de, field_odd;
    logic [HW+2:0] hpos;
    logic [VW+2:0] vpos;

    always #10 clk = ~clk;

    ilace_sync_gen #(.HW(HW), .VW(VW)) dut_i (
        .clk(clk), .rst_n(rst_n), .tv_en(tv_en), .ilace(ilace),
        .h_pw(h_pw), .h_bp(h_bp), .h_act(h_act), .h_fp(h_fp),
        .vo_pw(vo_pw), .vo_bp(vo_bp), .vo_act(vo_act), .vo_fp(vo_fp),
        .ve_pw(ve_pw), .ve_bp(ve_bp), .ve_act(ve_act), .ve_fp(ve_fp),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .de(de), .field_odd(field_odd),
        .hpos(hpos), .vpos(vpos)
    );

    int nchk = 0, nerr = 0;

    // behavioural reference state
    bit m_run = 0, m_f = 1, m_pend = 0;
    int m_h = 0, m_v = 0;
    int sh[4];
    int sv[4];

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic load_h();
        sh[0] = h_pw; sh[1] = h_bp; sh[2] = h_act; sh[3] = h_fp;
    endtask

    task automatic load_v(input bit odd);
        if (odd) begin sv[0] = vo_pw; sv[1] = vo_bp; sv[2] = vo_act; sv[3] = vo_fp; end
        else     begin sv[0] = ve_pw; sv[1] = ve_bp; sv[2] = ve_act; sv[3] = ve_fp; end
    endtask

    task automatic model_step();
        int len, hn, vt;
        bit fs;
        if (!rst_n || !tv_en) begin
            m_run = 0; m_h = 0; m_v = 0; m_f = 1; m_pend = 0;
        end else if (!m_run) begin
            m_run = 1; m_h = 0; m_v = 0; m_f = 1; m_pend = 0;
            load_h(); load_v(1'b1);
        end else begin
            len = sh[0] + sh[1] + sh[2] + sh[3] + 4;
            hn = (m_h == len - 1) ? 0 : m_h + 1;
            fs = 0;
            if (hn == 0 || hn == len / 2) begin
                vt = sv[0] + sv[1] + sv[2] + sv[3] + 4;
                if (m_v == vt - 1) begin
                    m_v = 0;
                    m_f = ilace ? !m_f : 1'b1;
                    load_v(m_f);
                    fs = 1;
                end else m_v++;
            end
            if (hn == 0 && (m_pend || fs)) begin load_h(); m_pend = 0; end
            else if (fs) m_pend = 1;
            m_h = hn;
        end
    endtask

    task automatic compare_all();
        bit ehs, evs, ede, ehact, evact;
        if (!m_run) begin
            ehs = 1; evs = 1; ede = 0;
        end else begin
            ehs = !(m_h <= sh[0]);
            evs = !(m_v <= sv[0]);
            ehact = (m_h >= sh[0] + sh[1] + 2) && (m_h < sh[0] + sh[1] + sh[2] + 3);
            evact = (m_v >= sv[0] + sv[1] + 2) && (m_v < sv[0] + sv[1] + sv[2] + 3);
            ede = ehact && evact;
        end
        chk(hsync_n == ehs, "R2", "hsync_n", hsync_n, ehs);
        chk(vsync_n == evs, "R3", "vsync_n", vsync_n, evs);
        chk(de == ede, "R6", "de", de, ede);
        chk(field_odd == m_f, "R7", "field_odd", field_odd, m_f);
        chk(int'(hpos) == m_h, "R2", "hpos", hpos, m_h);
        chk(int'(vpos) == m_v, "R3", "vpos", vpos, m_v);
    endtask

    task automatic tick_cycle();
        @(posedge clk);
        #1;
        model_step();
        compare_all();
    endtask

    task automatic poke_cfg();
        vo_fp = 6;
        h_pw  = 3;
    endtask

    // entered on the first low cycle of a vertical pulse; returns on the next one
    task automatic meas(input int poke, output int lo, output int per,
                        output bit fo, output int fh, output int rh);
        fo = field_odd; fh = hpos; lo = 0; per = 0;
        while (vsync_n == 1'b0) begin
            tick_cycle(); lo++; per++;
            if (per == poke) poke_cfg();
        end
        rh = hpos;
        while (vsync_n == 1'b1) begin
            tick_cycle(); per++;
            if (per == poke) poke_cfg();
        end
    endtask

    initial begin
        #2_000_000;
        nchk++; nerr++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        int lo, per, fh, rh;
        bit fo, exp_fo;
        h_pw = 1; h_bp = 2; h_act = 5; h_fp = 2;          // L = 14
        vo_pw = 3; vo_bp = 2; vo_act = 9; vo_fp = 4;      // 22 half-lines
        ve_pw = 4; ve_bp = 3; ve_act = 9; ve_fp = 3;      // 23 half-lines
        repeat (3) tick_cycle();
        chk(hsync_n && vsync_n && !de && field_odd && hpos == 0 && vpos == 0, "R1", "reset idle", de, 0);
        rst_n = 1'b1;
        repeat (3) tick_cycle();
        chk(hsync_n && vsync_n && !de && field_odd && hpos == 0 && vpos == 0, "R1", "disabled idle", hsync_n, 1);

        ilace = 1'b1; tv_en = 1'b1;
        tick_cycle();
        chk(hpos == 0 && vpos == 0, "R10", "origin position", int'(hpos) + int'(vpos), 0);
        chk(!hsync_n && !vsync_n && field_odd, "R10", "origin syncs", vsync_n, 0);

        // interlaced: fields alternate and field origins alternate line start / mid-line
        exp_fo = 1;
        for (int i = 0; i < 4; i++) begin
            meas(0, lo, per, fo, fh, rh);
            chk(fo == exp_fo, "R7", "field alternation", fo, exp_fo);
            chk(lo == (fo ? 4 : 5) * 7, "R4", "pulse length", lo, (fo ? 4 : 5) * 7);
            chk(rh == (fh + lo) % 14, "R4", "pulse end position", rh, (fh + lo) % 14);
            if (!fo) chk(rh != fh, "R4", "half-line edge", rh, (fh + 7) % 14);
            chk(per == (fo ? 22 : 23) * 7, "R5", "field period", per, (fo ? 22 : 23) * 7);
            exp_fo = !exp_fo;
        end

        // non-interlaced: even set disturbed but ignored
        ilace = 1'b0; ve_pw = 0; ve_fp = 20;
        meas(0, lo, per, fo, fh, rh);
        for (int i = 0; i < 3; i++) begin
            meas(0, lo, per, fo, fh, rh);
            chk(fo == 1, "R8", "field stays odd", fo, 1);
            chk(per == 154, "R8", "odd period only", per, 154);
            chk(lo == 28, "R8", "odd pulse only", lo, 28);
        end

        // mid-field change: current field keeps its timing
        meas(40, lo, per, fo, fh, rh);
        chk(per == 154, "R9", "field after mid change", per, 154);
        meas(0, lo, per, fo, fh, rh);
        chk(per == 24 * 8, "R9", "next field new timing", per, 24 * 8);
        chk(lo == 4 * 8, "R9", "pulse on new line length", lo, 4 * 8);

        // disable mid-field and restart
        repeat (30) tick_cycle();
        tv_en = 1'b0;
        repeat (4) tick_cycle();
        chk(hsync_n && vsync_n && !de && field_odd && hpos == 0 && vpos == 0, "R1", "disable mid-field", vpos, 0);
        tv_en = 1'b1; ilace = 1'b1;
        tick_cycle();
        chk(hpos == 0 && vpos == 0 && !vsync_n && field_odd, "R10", "restart origin", vpos, 0);
        repeat (600) tick_cycle();

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule